// File: doc/BRIEF.md
# Float to Fixed-Point Converter

This block turns an IEEE-754 single-precision number into a fixed-point integer of 16 or 32 bits. The integer is either signed or unsigned, and its number of fraction bits is chosen at run time. The caller presents the float operand, a two-bit target type, a fraction-bit count and a valid strobe. One clock later the block returns a 32-bit word and a matching valid strobe.

The result is the real value multiplied by two to the power of the fraction-bit count. Every bit below the fixed-point LSB is discarded, so rounding is toward zero. A value that does not fit the target clamps to the nearest bound of that target. NaN, zeros, denormals and negative inputs to unsigned targets all give zero. A 16-bit result fills the whole 32-bit word: signed results are sign-extended and unsigned results are zero-extended. The block raises no flags.

Top module: `fp2fix_conv`

## Requirements
- R1: The target type select uses these codes: 2'b00 signed 16-bit, 2'b01 unsigned 16-bit, 2'b10 signed 32-bit, 2'b11 unsigned 32-bit. For an in-range input, the result is the input value times 2^fbits, truncated toward zero. Examples: -1.75 to signed 16-bit with fbits 0 gives -1, and 0.75 to unsigned 16-bit with fbits 16 gives 49152.
- R2: The legal fraction-bit counts are 0 to 16 for 16-bit targets and 1 to 32 for 32-bit targets, and every legal count scales correctly.
- R3: Signed 16-bit results appear sign-extended across bits 31:16. Unsigned 16-bit results have bits 31:16 equal to zero.
- R4: A positive value above the target maximum returns that maximum: 32767, 65535, 0x7FFFFFFF or 0xFFFFFFFF. A negative value below a signed target's minimum returns that minimum: 0xFFFF8000 or 0x80000000.
- R5: Any negative input converted to an unsigned type gives 0.
- R6: Any NaN input gives 0.
- R7: +infinity gives the target maximum. -infinity gives the signed minimum, or 0 for an unsigned target.
- R8: +0, -0 and all denormal inputs give 0.
- R9: out_valid is high in exactly the cycle after each cycle in which in_valid is high. out_result keeps its value while no new operand is accepted.
- R10: While reset is asserted, out_valid and out_result are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_float | input | 32 | Single-precision operand |
| in_kind | input | 2 | Target type code (see R1) |
| in_fbits | input | 6 | Number of fraction bits |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 32 | Fixed-point result, extended to 32 bits |

## Verification
The only state is the output register and its strobe, so a wrong value shows at the ports in the cycle after the operand is taken. There is no longer history for an error to hide in. A faulty shift-amount computation shows up as results off by a power of two, and it appears first at exponents near the saturation edge. A faulty limit selection shows up as the wrong bound on overflow or infinity for one particular type code. A hold fault shows up as out_result changing during an idle cycle.

// File: rtl/fp2fix_pkg.sv
package fp2fix_pkg;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int BIAS  = 127;
  localparam int FLT_W = 1 + EXP_W + MAN_W;

  typedef enum logic [1:0] {
    FX_S16 = 2'b00,
    FX_U16 = 2'b01,
    FX_S32 = 2'b10,
    FX_U32 = 2'b11
  } fx_kind_e;

  typedef struct packed {
    logic             sign;
    logic             is_nan;
    logic             is_inf;
    logic             is_zero;
    logic [EXP_W-1:0] exp;
    logic [MAN_W:0]   sig;
  } fp_fields_t;
endpackage

// File: rtl/fp2fix_unpack.sv
module fp2fix_unpack
  import fp2fix_pkg::*;
(
  input  logic [FLT_W-1:0] op,
  output fp_fields_t       fields
);
  logic [EXP_W-1:0] e;
  logic [MAN_W-1:0] m;
  logic             e_all1;
  logic             e_all0;

  assign e      = op[FLT_W-2 -: EXP_W];
  assign m      = op[MAN_W-1:0];
  assign e_all1 = &e;
  assign e_all0 = ~|e;

  always_comb begin
    fields.sign    = op[FLT_W-1];
    fields.is_nan  = e_all1 && (m != '0);
    fields.is_inf  = e_all1 && (m == '0);
    // denormals are flushed together with true zeros
    fields.is_zero = e_all0;
    fields.exp     = e;
    fields.sig     = {1'b1, m};
  end
endmodule

// File: rtl/fp2fix_scale.sv
module fp2fix_scale
  import fp2fix_pkg::*;
#(
  parameter int OUT_W = 32,
  parameter int FB_W  = 6
) (
  input  fp_fields_t       fields,
  input  logic [FB_W-1:0]  fbits,
  output logic [OUT_W:0]   mag,
  output logic             ovf
);
  localparam int MAG_W    = OUT_W + 1;
  localparam int SH_W     = EXP_W + 3;
  localparam int MAX_LSH  = MAG_W - (MAN_W + 1);
  localparam int EXP_OFFS = BIAS + MAN_W;

  logic [SH_W-1:0]  sh;
  logic [SH_W-1:0]  rsh;
  logic             sh_neg;
  logic [MAG_W-1:0] sig_ext;

  assign sh      = SH_W'(fields.exp) - SH_W'(EXP_OFFS) + SH_W'(fbits);
  assign sh_neg  = sh[SH_W-1];
  assign rsh     = SH_W'(0) - sh;
  assign sig_ext = MAG_W'(fields.sig);

  always_comb begin
    ovf = 1'b0;
    mag = '0;
    if (!sh_neg) begin
      if (sh > SH_W'(MAX_LSH)) ovf = 1'b1;
      else                     mag = sig_ext << sh;
    end else if (rsh <= SH_W'(MAN_W)) begin
      mag = sig_ext >> rsh;
    end
  end
endmodule

// File: rtl/fp2fix_clamp.sv
module fp2fix_clamp
  import fp2fix_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  logic [1:0]       kind,
  input  fp_fields_t       fields,
  input  logic [OUT_W:0]   mag,
  input  logic             ovf,
  output logic [OUT_W-1:0] result
);
  localparam int MAG_W  = OUT_W + 1;
  localparam int HALF_W = OUT_W / 2;

  logic             wide;
  logic             uns;
  logic [MAG_W-1:0] pos_lim;
  logic [MAG_W-1:0] neg_lim;
  logic [MAG_W-1:0] neg_mag;

  assign wide = kind[1];
  assign uns  = kind[0];

  generate
    if (HALF_W > 1) begin : g_lim
      always_comb begin
        case ({wide, uns})
          2'b00:   pos_lim = (MAG_W'(1) << (HALF_W - 1)) - MAG_W'(1);
          2'b01:   pos_lim = (MAG_W'(1) << HALF_W) - MAG_W'(1);
          2'b10:   pos_lim = (MAG_W'(1) << (OUT_W - 1)) - MAG_W'(1);
          default: pos_lim = (MAG_W'(1) << OUT_W) - MAG_W'(1);
        endcase
        neg_lim = wide ? (MAG_W'(1) << (OUT_W - 1)) : (MAG_W'(1) << (HALF_W - 1));
      end
    end
  endgenerate

  always_comb begin
    neg_mag = '0;
    result  = '0;
    if (fields.is_nan || fields.is_zero) begin
      result = '0;
    end else if (fields.sign) begin
      if (uns) begin
        result = '0;
      end else begin
        neg_mag = (fields.is_inf || ovf || mag > neg_lim) ? neg_lim : mag;
        result  = OUT_W'(MAG_W'(0) - neg_mag);
      end
    end else if (fields.is_inf || ovf || mag > pos_lim) begin
      result = OUT_W'(pos_lim);
    end else begin
      result = OUT_W'(mag);
    end
  end
endmodule

// File: rtl/fp2fix_conv.sv
module fp2fix_conv
  import fp2fix_pkg::*;
#(
  parameter int OUT_W = 32,
  parameter int FB_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [31:0]      in_float,
  input  logic [1:0]       in_kind,
  input  logic [FB_W-1:0]  in_fbits,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_result
);
  localparam int HALF_W = OUT_W / 2;

  fp_fields_t       fields;
  logic [OUT_W:0]   mag;
  logic             ovf;
  logic [OUT_W-1:0] conv;

  fp2fix_unpack u_unpack (
    .op     (in_float),
    .fields (fields)
  );

  fp2fix_scale #(.OUT_W(OUT_W), .FB_W(FB_W)) u_scale (
    .fields (fields),
    .fbits  (in_fbits),
    .mag    (mag),
    .ovf    (ovf)
  );

  fp2fix_clamp #(.OUT_W(OUT_W)) u_clamp (
    .kind   (in_kind),
    .fields (fields),
    .mag    (mag),
    .ovf    (ovf),
    .result (conv)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= conv;
    end
  end

  // R9
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R9
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result));
  // R6
  nan_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fields.is_nan) |=> (out_result == '0));
  // R8
  tiny_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fields.is_zero) |=> (out_result == '0));
  // R5
  uns_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fields.sign && in_kind[0]) |=> (out_result == '0));
  // R3
  u16_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == FX_U16) |=> (out_result[OUT_W-1:HALF_W] == '0));
  // R3
  s16_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == FX_S16) |=>
      (out_result[OUT_W-1:HALF_W-1] == '0 || out_result[OUT_W-1:HALF_W-1] == '1));
endmodule

// File: tb/fp2fix_conv_test.sv
module fp2fix_conv_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_float = '0;
  logic [1:0]  in_kind = '0;
  logic [5:0]  in_fbits = '0;
  logic        out_valid;
  logic [31:0] out_result;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fp2fix_conv uut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_float   (in_float),
    .in_kind    (in_kind),
    .in_fbits   (in_fbits),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  function automatic logic [31:0] ref_conv(logic [31:0] x, logic [1:0] k, int fb);
    int     e;
    bit     neg;
    longint hi, lo, t, v;
    real    r;
    e   = int'(x[30:23]);
    neg = x[31];
    case (k)
      2'b00:   begin hi = 64'sd32767;      lo = -64'sd32768;      end
      2'b01:   begin hi = 64'sd65535;      lo = 64'sd0;           end
      2'b10:   begin hi = 64'sd2147483647; lo = -64'sd2147483648; end
      default: begin hi = 64'sd4294967295; lo = 64'sd0;           end
    endcase
    if (e == 255) begin
      if (x[22:0] != 0) return 32'h0;
      v = neg ? lo : hi;
      return v[31:0];
    end
    if (e == 0) return 32'h0;
    r = (8388608.0 + real'(x[22:0])) * (2.0 ** (e - 150 + fb));
    if (r >= 1099511627776.0) t = 64'sd1099511627776;
    else                      t = longint'($floor(r));
    v = neg ? -t : t;
    if (v > hi) v = hi;
    if (v < lo) v = lo;
    return v[31:0];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic apply(string req, logic [31:0] x, logic [1:0] k, int fb);
    logic [31:0] exp;
    exp = ref_conv(x, k, fb);
    @(negedge clk);
    in_valid = 1'b1;
    in_float = x;
    in_kind  = k;
    in_fbits = 6'(fb);
    @(negedge clk);
    in_valid = 1'b0;
    in_float = $urandom;
    check({req, " valid (R9)"}, {31'b0, out_valid}, 32'h1);
    check(req, out_result, exp);
  endtask

  task automatic idle_check(logic [31:0] prev);
    @(negedge clk);
    check("R9 idle valid", {31'b0, out_valid}, 32'h0);
    check("R9 hold", out_result, prev);
  endtask

  function automatic int legal_fb(logic [1:0] k);
    if (k[1]) return 1 + int'($urandom_range(31));
    return int'($urandom_range(16));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] dummy;
    dummy = $urandom(32'h5eed);
    in_valid = 1'b1;
    in_float = 32'h3F800000;
    repeat (3) @(negedge clk);
    // R10: reset holds outputs low even with in_valid high
    check("R10 valid", {31'b0, out_valid}, 32'h0);
    check("R10 result", out_result, 32'h0);
    in_valid = 1'b0;
    rst = 1'b0;

    apply("R1 1.0 S16", 32'h3F800000, 2'b00, 0);
    apply("R1 -1.75 trunc S16", 32'hBFE00000, 2'b00, 0);
    apply("R1 -1.5 S32 fb1", 32'hBFC00000, 2'b10, 1);
    apply("R2 0.75 U16 fb16", 32'h3F400000, 2'b01, 16);
    apply("R2 1.0 U32 fb32", 32'h3F800000, 2'b11, 32);
    apply("R2 0.5 S32 fb32", 32'h3F000000, 2'b10, 32);
    apply("R3 -1.0 S16 ext", 32'hBF800000, 2'b00, 4);
    apply("R3 65535 U16", 32'h477FFF00, 2'b01, 0);
    idle_check(32'h0000FFFF);
    apply("R4 65536 U16 sat", 32'h47800000, 2'b01, 0);
    apply("R4 40000 S16 sat", 32'h471C4000, 2'b00, 0);
    apply("R4 -40000 S16 sat", 32'hC71C4000, 2'b00, 0);
    apply("R4 -32768 S16 exact", 32'hC7000000, 2'b00, 0);
    apply("R4 -2^30 S32 fb1 exact", 32'hCE800000, 2'b10, 1);
    apply("R4 2^31 U32 fb1 sat", 32'h4F000000, 2'b11, 1);
    apply("R5 -3.0 U32", 32'hC0400000, 2'b11, 1);
    apply("R5 -inf U16", 32'hFF800000, 2'b01, 0);
    apply("R6 qnan S32", 32'h7FC00000, 2'b10, 5);
    apply("R6 snan S16", 32'hFF800001, 2'b00, 0);
    apply("R7 +inf S32", 32'h7F800000, 2'b10, 1);
    apply("R7 -inf S16", 32'hFF800000, 2'b00, 3);
    apply("R7 +inf U16", 32'h7F800000, 2'b01, 0);
    apply("R8 denormal", 32'h00000001, 2'b10, 32);
    apply("R8 -0", 32'h80000000, 2'b00, 0);
    idle_check(32'h0);

    for (int i = 0; i < 600; i++) begin
      logic [31:0] x;
      logic [1:0]  k;
      k = 2'($urandom);
      x = $urandom;
      if (i % 4 != 0) x[30:23] = 8'(100 + $urandom_range(70));
      apply("R1 random", x, k, legal_fb(k));
      if (i % 50 == 0) idle_check(ref_conv(x, k, int'(in_fbits)));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule